// File: doc/BRIEF.md
# Uniform Crossover and Single-Bit Mutation Unit

This block performs one genetic step on a pair of 32-bit parent words. When the upstream sorter raises its ready line, the unit takes a snapshot of a free-running pseudo-random register and uses it as a uniform crossover mask. Where a mask bit is 1 the two parents swap that bit, and where it is 0 each child keeps its own parent's bit. The two offspring then each have exactly one bit inverted. A second small pseudo-random register picks the bit position, and a 5-to-32 one-hot decoder turns that position into the flip vector. When the step is complete, a single-cycle done pulse tells the downstream stage that both children are valid.

Several copies of the unit can run side by side. Each copy takes its pseudo-random seeds as parameters, so that copies with different seeds draw different masks from the same parents. The children stay on the outputs until the next step replaces them. Writing them back into a population is the job of other logic.

Top module: `xover_mut_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `child_a`, `child_b` and `done` are cleared, the mask register loads `MASK_SEED` (default 32'h1357_9BDF) and the position register loads `POS_SEED` (default 5'h00).
- R2: On every rising edge with `rst` low, the 32-bit mask register m steps to {m[30:0], ~(m[31]^m[21]^m[1]^m[0])}, whether or not a step is in progress.
- R3: On every rising edge with `rst` low, the 5-bit position register q steps to {q[3:0], ~(q[4]^q[2])}. It visits 31 states and never reaches 5'b11111, so index 31 is never chosen for the first child.
- R4: A step starts only at a rising edge where `sort_rdy` is high and was low at the previous edge (it reads as low at the first edge after reset). At that edge the parents and the current values of both registers are captured. Keeping `sort_rdy` high does not start another step, and parent changes after the capture edge have no effect on that step.
- R5: With captured mask C and parents P1 = `parent_a`, P2 = `parent_b`, the crossover words are X1 = (P1 & ~C) | (P2 & C) and X2 = (P2 & ~C) | (P1 & C).
- R6: `child_a` = X1 with bit q inverted, and `child_b` = X2 with bit q' inverted. Here q is the captured position value, q' is its R3 successor, and bit 0 is the LSB. Each child therefore differs from its crossover word in exactly one bit.
- R7: If the start edge is edge k, the new children and a one-cycle `done` pulse appear at edge k+1. `done` is never high in two consecutive cycles.
- R8: Between steps, `child_a` and `child_b` hold their last values, whatever the parent inputs do.
- R9: Two units that differ only in `MASK_SEED` produce different children from the same stimulus.
- R10: Steps whose `sort_rdy` pulses are separated by a single low cycle are each completed, in order, with their own done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the unit runs while it is low |
| sort_rdy | input | 1 | Ready level from the sorter; its rising edge starts a step |
| parent_a | input | 32 | First parent word |
| parent_b | input | 32 | Second parent word |
| child_a | output | 32 | First offspring, registered |
| child_b | output | 32 | Second offspring, registered |
| done | output | 1 | One-cycle pulse when the children are updated |

## Verification
Both children and the done pulse are due one edge after the start edge, which is two rising edges after the negative edge at which the driver raises `sort_rdy`. When the driver starts a step, it stamps the expected pair with the bench cycle count at which that pair is due. The monitor samples on falling edges. Whenever `done` is high it pops one entry and checks both the stamp and the two words. On every other cycle it checks that the outputs have not moved. The expected words come from bench models of both pseudo-random registers, read at the same negative edge at which `sort_rdy` is raised, which is the value the design captures at the next rising edge.

// File: rtl/xm_pkg.sv
package xm_pkg;
  // Feedback tap masks (bit i set = register bit i feeds the XNOR)
  localparam logic [31:0] XM_MASK_TAPS = 32'h8020_0003;
  localparam logic [4:0]  XM_POS_TAPS  = 5'b1_0100;
  localparam logic [31:0] XM_MASK_SEED = 32'h1357_9BDF;
  localparam logic [4:0]  XM_POS_SEED  = 5'h00;
endpackage

// File: rtl/xm_lfsr.sv
module xm_lfsr #(
  parameter int            W     = 32,
  parameter logic [W-1:0]  TAPS  = '1,
  parameter logic [W-1:0]  SEED  = '0
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next
);
  logic fb;

  assign fb     = ~^(q & TAPS);
  assign q_next = {q[W-2:0], fb};

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= q_next;
  end

  // R3 (and R2): the XNOR lock-up state is never entered from a legal seed
  no_lockup_chk: assert property (@(posedge clk) disable iff (rst)
    q != {W{1'b1}});
endmodule

// File: rtl/xm_onehot.sv
module xm_onehot #(
  parameter int IDX_W = 5,
  parameter int OUT_W = 32
) (
  input  logic [IDX_W-1:0] idx,
  output logic [OUT_W-1:0] oh
);
  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    assign oh[i] = (idx == IDX_W'(i));
  end
endmodule

// File: rtl/xover_mut_unit.sv
module xover_mut_unit
  import xm_pkg::*;
#(
  parameter int                          WORD_W    = 32,
  parameter logic [WORD_W-1:0]           MASK_TAPS = XM_MASK_TAPS,
  parameter logic [WORD_W-1:0]           MASK_SEED = XM_MASK_SEED,
  parameter logic [$clog2(WORD_W)-1:0]   POS_TAPS  = XM_POS_TAPS,
  parameter logic [$clog2(WORD_W)-1:0]   POS_SEED  = XM_POS_SEED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sort_rdy,
  input  logic [WORD_W-1:0] parent_a,
  input  logic [WORD_W-1:0] parent_b,
  output logic [WORD_W-1:0] child_a,
  output logic [WORD_W-1:0] child_b,
  output logic              done
);
  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] mask_q, mask_nx;
  logic [IDX_W-1:0]  pos_q, pos_nx;

  xm_lfsr #(.W(WORD_W), .TAPS(MASK_TAPS), .SEED(MASK_SEED)) u_mask_lfsr (
    .clk(clk), .rst(rst), .q(mask_q), .q_next(mask_nx));

  xm_lfsr #(.W(IDX_W), .TAPS(POS_TAPS), .SEED(POS_SEED)) u_pos_lfsr (
    .clk(clk), .rst(rst), .q(pos_q), .q_next(pos_nx));

  // Stage 1: edge detect and capture
  logic              rdy_q, start, s1_v;
  logic [WORD_W-1:0] mask_r, pa_r, pb_r;
  logic [IDX_W-1:0]  ia_r, ib_r;

  assign start = sort_rdy & ~rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q  <= 1'b0;
      s1_v   <= 1'b0;
      mask_r <= '0;
      pa_r   <= '0;
      pb_r   <= '0;
      ia_r   <= '0;
      ib_r   <= '0;
    end else begin
      rdy_q <= sort_rdy;
      s1_v  <= start;
      if (start) begin
        mask_r <= mask_q;
        pa_r   <= parent_a;
        pb_r   <= parent_b;
        ia_r   <= pos_q;
        ib_r   <= pos_nx;
      end
    end
  end

  // Stage 2: crossover then single-bit mutation
  logic [WORD_W-1:0] xo_a, xo_b, flip_a, flip_b;

  assign xo_a = (pa_r & ~mask_r) | (pb_r & mask_r);
  assign xo_b = (pb_r & ~mask_r) | (pa_r & mask_r);

  xm_onehot #(.IDX_W(IDX_W), .OUT_W(WORD_W)) u_dec_a (.idx(ia_r), .oh(flip_a));
  xm_onehot #(.IDX_W(IDX_W), .OUT_W(WORD_W)) u_dec_b (.idx(ib_r), .oh(flip_b));

  always_ff @(posedge clk) begin
    if (rst) begin
      child_a <= '0;
      child_b <= '0;
      done    <= 1'b0;
    end else begin
      done <= s1_v;
      if (s1_v) begin
        child_a <= xo_a ^ flip_a;
        child_b <= xo_b ^ flip_b;
      end
    end
  end

  // R4
  start_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (sort_rdy && !rdy_q) |=> s1_v);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    s1_v |=> done);

  // R6
  one_flip_a_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $countones(child_a ^ $past(xo_a)) == 1);

  // R6
  one_flip_b_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $countones(child_b ^ $past(xo_b)) == 1);

  // R5
  swap_conserve_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $countones(child_a ^ child_b ^ $past(pa_r ^ pb_r)) <= 2);

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(child_a) && $stable(child_b)));
endmodule

// File: tb/test_xover_mut_unit.sv
`timescale 1ns/1ps
module test_xover_mut_unit;
  localparam logic [31:0] SEED_M  = 32'h1357_9BDF;
  localparam logic [4:0]  SEED_P  = 5'h00;
  localparam logic [31:0] SEED_M2 = 32'h0BAD_F00D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sort_rdy = 1'b0;
  logic [31:0] parent_a = '0, parent_b = '0;
  logic [31:0] child_a, child_b, child2_a, child2_b;
  logic        done, done2;

  always #2.5 clk = ~clk;

  xover_mut_unit i_xover_mut_unit (
    .clk(clk), .rst(rst), .sort_rdy(sort_rdy), .parent_a(parent_a),
    .parent_b(parent_b), .child_a(child_a), .child_b(child_b), .done(done));

  xover_mut_unit #(.MASK_SEED(SEED_M2)) i_xover_mut_unit_b (
    .clk(clk), .rst(rst), .sort_rdy(sort_rdy), .parent_a(parent_a),
    .parent_b(parent_b), .child_a(child2_a), .child_b(child2_b), .done(done2));

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0, differ_seen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference models of the two pseudo-random registers (R2, R3)
  function automatic logic [31:0] m_step(logic [31:0] v);
    return {v[30:0], ~(v[31] ^ v[21] ^ v[1] ^ v[0])};
  endfunction
  function automatic logic [4:0] p_step(logic [4:0] v);
    return {v[3:0], ~(v[4] ^ v[2])};
  endfunction

  logic [31:0] m_mod;
  logic [4:0]  p_mod;
  always @(posedge clk) begin
    m_mod <= rst ? SEED_M : m_step(m_mod);
    p_mod <= rst ? SEED_P : p_step(p_mod);
  end

  typedef struct { logic [31:0] a; logic [31:0] b; int due; } exp_t;
  exp_t sb[$];
  logic [31:0] last_a = '0, last_b = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver: start one step, keep ready high for hi cycles, low for lo cycles
  task automatic op(input logic [31:0] p1, input logic [31:0] p2, input int hi, input int lo);
    exp_t e;
    logic [31:0] x1, x2;
    @(negedge clk);
    parent_a = p1;
    parent_b = p2;
    sort_rdy = 1'b1;
    x1 = (p1 & ~m_mod) | (p2 & m_mod);
    x2 = (p2 & ~m_mod) | (p1 & m_mod);
    e.a = x1 ^ (32'd1 << p_mod);
    e.b = x2 ^ (32'd1 << p_step(p_mod));
    e.due = cyc + 2;
    sb.push_back(e);
    for (int i = 1; i < hi; i++) begin
      @(negedge clk);
      parent_a = ~p1 ^ 32'(i);   // R4: changes after capture are ignored
      parent_b = p2 + 32'(i);
    end
    @(negedge clk);
    sort_rdy = 1'b0;
    for (int i = 1; i < lo; i++) @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R7 done without pending step", {31'd0, done}, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(e.due == cyc, "R7 done timing", 32'(cyc), 32'(e.due));
          chk(child_a === e.a, "R2 R3 R5 R6 child_a", child_a, e.a);
          chk(child_b === e.b, "R2 R3 R5 R6 child_b", child_b, e.b);
          if (child2_a !== child_a || child2_b !== child_b) differ_seen = 1;
        end
        last_a = child_a;
        last_b = child_b;
      end else begin
        chk(child_a === last_a, "R8 child_a hold", child_a, last_a);
        chk(child_b === last_b, "R8 child_b hold", child_b, last_b);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(child_a === 32'd0, "R1 reset child_a", child_a, 32'd0);
    chk(child_b === 32'd0, "R1 reset child_b", child_b, 32'd0);
    chk(done === 1'b0, "R1 reset done", {31'd0, done}, 32'd0);
    rst = 1'b0;

    op(32'h0000_0000, 32'hFFFF_FFFF, 1, 3);   // R5 mask exposed
    op(32'hFFFF_FFFF, 32'h0000_0000, 5, 3);   // R4 held ready
    op(32'hA5A5_A5A5, 32'h5A5A_5A5A, 1, 2);
    // R8: parents wander with no ready edge
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      parent_a = 32'h1111_1111 * 32'(i);
      parent_b = ~parent_a;
    end
    // R10: back-to-back pulses with one low cycle between
    for (int i = 0; i < 6; i++)
      op(32'hDEAD_0000 | 32'(i), 32'h0000_BEEF << i, 1, 1);
    // R3: enough steps to wrap the position register
    for (int i = 0; i < 40; i++)
      op(32'h9E37_79B9 * 32'(i + 1), 32'h7F4A_7C15 ^ (32'h0101_0101 << (i % 8)),
         1 + (i % 3), 1 + (i % 2));
    repeat (6) @(negedge clk);
    chk(sb.size() == 0, "R7 all steps completed", 32'(sb.size()), 32'd0);
    chk(differ_seen == 1'b1, "R9 seeds give distinct children", {31'd0, differ_seen}, 32'd1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule